// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer reached over a simple 32-bit register bus. It has three registers:

- a control word;
- a reload word;
- a live 16-bit down-counter.

The system clock first passes through an 8-bit prescaler that divides by the programmed value plus one. A second divider then divides by 16, 32, 64 or 128, chosen by a 2-bit select field. Each output of this chain is one timer tick, and each tick decrements the counter.

When a tick arrives while the counter already holds zero, the counter takes the reload word again. If the reset-enable bit is also set at that moment, the block drives a system reset request for a fixed number of clocks.

Software keeps the system alive by writing the counter register before it runs out. To stop the watchdog, software clears the control word. To force a reset almost at once, software runs three writes in order:

1. Clear the control word.
2. Load the counter with 1.
3. Set the enable and reset-enable bits together.

Top module: `wdt_top`

## Requirements
- R1: After the synchronous reset, the control register reads 0x00000000. The reload and counter registers read 0x00008000, and `wd_reset` is low.
- R2: Register offsets are 0x0 for control, 0x4 for reload and 0x8 for the counter, and offset 0xC reads zero. The control register fields are:
  - prescale in bits [15:8];
  - enable in bit 5;
  - divider select in bits [4:3];
  - reset-enable in bit 0.
  
  These fields read back exactly as written, and every other control bit reads 0.
- R3: With enable set, one tick occurs every (prescale+1)·2^(4+select) clocks. The first tick comes that many clocks after the write that sets enable.
- R4: Each tick decrements a nonzero counter by one. A tick that finds the counter at zero reloads it from the reload register, so a count of V expires on the (V+1)-th tick.
- R5: A bus write to the counter register loads that value directly and wins over a tick in the same cycle. Rewriting the counter in time prevents any reset.
- R6: `wd_reset` rises only on the clock after an expiring tick with both enable and reset-enable set. An expiry with reset-enable clear reloads the counter silently.
- R7: Each reset request stays high for exactly RST_CYCLES clocks (128 by default).
- R8: While enable is clear, the counter holds its value, the prescaler and divider stay cleared, and no reset is produced even if reset-enable is set.
- R9: The sequence "control←0, counter←1, control←enable|reset-enable" raises `wd_reset` 2·(prescale+1)·2^(4+select) clocks after the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| wd_reset | output | 1 | System reset request pulse |

## Verification
Each register write takes effect at the clock edge that samples it, and reads return the value in the same cycle. The bench therefore samples on falling edges, one edge after the write.

The reset request rises exactly (V+1)·(prescale+1)·2^(4+select) rising edges after the write that sets enable. The bench counts falling edges from that write until `wd_reset` is seen, and compares the count with that product.

The pulse width is counted the same way. The counter value is read at computed tick boundaries, such as directly after an expiry or a fixed number of ticks after enable.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PRE_W        = 8;
    localparam int SEL_W        = 2;
    localparam int CNT_W        = 16;
    localparam int DIV_LOG_BASE = 4;
    localparam int DIV_W        = DIV_LOG_BASE + (1 << SEL_W) - 1;
    localparam int BUS_W        = 32;
    localparam int ADDR_W       = 4;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             en;
        logic [SEL_W-1:0] sel;
        logic             rst_en;
    } wdt_ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_NONE   = 2'd3
    } wdt_reg_e;

    // Control word layout: prescale [15:8], enable [5], select [4:3], reset-enable [0]
    function automatic logic [BUS_W-1:0] ctrl_pack(input wdt_ctrl_t c);
        logic [BUS_W-1:0] w;
        w         = '0;
        w[15:8]   = c.pre;
        w[5]      = c.en;
        w[4:3]    = c.sel;
        w[0]      = c.rst_en;
        return w;
    endfunction

    function automatic wdt_ctrl_t ctrl_unpack(input logic [BUS_W-1:0] w);
        wdt_ctrl_t c;
        c.pre    = w[15:8];
        c.en     = w[5];
        c.sel    = w[4:3];
        c.rst_en = w[0];
        return c;
    endfunction

    function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] sel);
        logic [DIV_W:0] span;
        span = (DIV_W+1)'(1) << (DIV_LOG_BASE + int'(sel));
        return DIV_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count_in,
    output wdt_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_load_val
);

    wdt_reg_e reg_idx;
    logic     wr_ctrl;
    logic     wr_reload;

    assign reg_idx      = wdt_reg_e'(bus_addr[3:2]);
    assign wr_ctrl      = bus_sel && bus_wr && (reg_idx == REG_CTRL);
    assign wr_reload    = bus_sel && bus_wr && (reg_idx == REG_RELOAD);
    assign cnt_load     = bus_sel && bus_wr && (reg_idx == REG_COUNT);
    assign cnt_load_val = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= RESET_LOAD;
        end else begin
            if (wr_ctrl)   ctrl   <= ctrl_unpack(bus_wdata);
            if (wr_reload) reload <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (reg_idx)
                REG_CTRL:   bus_rdata = ctrl_pack(ctrl);
                REG_RELOAD: bus_rdata = BUS_W'(reload);
                REG_COUNT:  bus_rdata = BUS_W'(count_in);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_tickgen.sv
module wdt_tickgen
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] pre,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic             pre_hit;
    logic             div_hit;

    // >= keeps the chain from running past a limit lowered mid-period
    assign pre_hit = (pre_q >= pre);
    assign div_hit = (div_q >= div_last(sel));
    assign tick    = en && pre_hit && div_hit;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (pre_hit) begin
            pre_q <= '0;
            div_q <= div_hit ? '0 : div_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    assign expire = tick && !load && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= RESET_LOAD;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= (count == '0) ? reload : count - 1'b1;
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int RST_CYCLES = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse
);

    localparam int LEN_W = $clog2(RST_CYCLES + 1);

    logic [LEN_W-1:0] left_q;

    assign pulse = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LEN_W'(RST_CYCLES);
        end else if (pulse) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int               RST_CYCLES = 128,
    parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wd_reset
);

    wdt_ctrl_t        ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             tick;
    logic             expire;
    logic             ctrl_en;
    logic             ctrl_rst_en;
    logic             fire;

    assign ctrl_en     = ctrl.en;
    assign ctrl_rst_en = ctrl.rst_en;
    assign fire        = expire && ctrl_en && ctrl_rst_en;

    wdt_regs #(.RESET_LOAD(RESET_LOAD)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .count_in     (count),
        .ctrl         (ctrl),
        .reload       (reload),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val)
    );

    wdt_tickgen u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl_en),
        .pre  (ctrl.pre),
        .sel  (ctrl.sel),
        .tick (tick)
    );

    wdt_counter #(.RESET_LOAD(RESET_LOAD)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .reload   (reload),
        .count    (count),
        .expire   (expire)
    );

    wdt_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .pulse (wd_reset)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              rst_en,
    input logic              tick,
    input logic [CNT_W-1:0]  count,
    input logic              cnt_load,
    input logic [CNT_W-1:0]  load_val,
    input logic              wd_reset,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_rdata
);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)           hi_cnt <= '0;
        else if (wd_reset) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
        else               hi_cnt <= '0;
    end

    assert_ctrl_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr[3:2] == 2'd0) |-> ((bus_rdata & 32'hFFFF_00C6) == 32'd0));

    assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && count != '0) |=> (count == $past(count) - 1'b1));

    assert_direct_load_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> (count == $past(load_val)));

    assert_reset_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_reset) |-> $past(en && rst_en && tick && !cnt_load && count == '0));

    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_reset) |-> (hi_cnt >= 16'(RST_CYCLES)));

    assert_no_tick_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_load) |=> $stable(count));

endmodule

bind wdt_top wdt_checker #(.RST_CYCLES(RST_CYCLES)) u_wdt_checker (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_en),
    .rst_en    (ctrl_rst_en),
    .tick      (tick),
    .count     (count),
    .cnt_load  (cnt_load),
    .load_val  (cnt_load_val),
    .wd_reset  (wd_reset),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/wdt_top_test.sv
module wdt_top_test;

    localparam int RST_CYCLES = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_reset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit rst_seen = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    wdt_top #(.RST_CYCLES(RST_CYCLES)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wd_reset  (wd_reset)
    );

    always @(negedge clk) if (wd_reset) rst_seen = 1'b1;

    function automatic logic [31:0] mk_ctrl(input int pre, input int sel, input bit en, input bit ren);
        logic [31:0] w;
        w       = '0;
        w[15:8] = pre[7:0];
        w[5]    = en;
        w[4:3]  = sel[1:0];
        w[0]    = ren;
        return w;
    endfunction

    // driver side of the scoreboard
    task automatic push_exp(input string tag, input logic [31:0] v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        exp_q.push_back(e);
    endtask

    // monitor side: pops the oldest expectation and compares
    task automatic observe(input logic [31:0] act);
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard-empty actual=%0h expected=none", act);
        end else begin
            e = exp_q.pop_front();
            if (act !== e.val) begin
                fails++;
                $display("FAIL %s actual=%0h expected=%0h", e.tag, act, e.val);
            end
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [3:0] a, input logic [31:0] v);
        logic [31:0] d;
        push_exp(tag, v);
        bus_read(a, d);
        observe(d);
    endtask

    // counts falling edges after the last write until wd_reset is seen
    task automatic wait_reset(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n++;
            if (wd_reset) break;
        end
    endtask

    task automatic pulse_width(output int w);
        w = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (wd_reset) w++;
            else break;
        end
    endtask

    task automatic expire_run(input string tag, input int pre, input int sel, input int v, input logic [31:0] rel);
        int n;
        int w;
        int period;
        period = (pre + 1) * (16 << sel);
        bus_write(4'h0, 32'd0);
        bus_write(4'h4, rel);
        bus_write(4'h8, 32'(v));
        bus_write(4'h0, mk_ctrl(pre, sel, 1'b1, 1'b1));
        push_exp({tag, " latency"}, 32'(period * (v + 1)));
        wait_reset(period * (v + 2) + 10, n);
        observe(32'(n));
        read_check("R4 reload after expiry", 4'h8, rel);
        push_exp("R7 pulse width", 32'(RST_CYCLES));
        pulse_width(w);
        observe(32'(w));
        bus_write(4'h0, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        push_exp("R1 reset wd_reset", 32'd0);
        observe(32'(wd_reset));
        read_check("R1 reset ctrl", 4'h0, 32'h0);
        read_check("R1 reset reload", 4'h4, 32'h8000);
        read_check("R1 reset count", 4'h8, 32'h8000);

        // R2 control layout and readback
        bus_write(4'h0, 32'hFFFF_FFFF);
        read_check("R2 ctrl all ones", 4'h0, 32'h0000_FF39);
        bus_write(4'h0, mk_ctrl(8'hA5, 2, 1'b0, 1'b0));
        read_check("R2 ctrl fields", 4'h0, 32'h0000_A510);
        read_check("R2 unmapped offset", 4'hC, 32'h0);
        bus_write(4'h0, 32'd0);

        // R5 direct load and reload register
        bus_write(4'h8, 32'h1234);
        read_check("R5 count write", 4'h8, 32'h1234);
        bus_write(4'h4, 32'h0005);
        read_check("R5 reload write", 4'h4, 32'h5);

        // R8 idle hold with reset-enable only
        rst_seen = 1'b0;
        bus_write(4'h8, 32'd3);
        bus_write(4'h0, mk_ctrl(0, 0, 1'b0, 1'b1));
        repeat (300) @(negedge clk);
        read_check("R8 count held while disabled", 4'h8, 32'd3);
        push_exp("R8 no reset while disabled", 32'd0);
        observe(32'(rst_seen));

        // R3/R4 tick period and decrement
        bus_write(4'h0, 32'd0);
        bus_write(4'h8, 32'd10);
        bus_write(4'h0, mk_ctrl(0, 0, 1'b1, 1'b0));
        repeat (47) @(negedge clk);
        read_check("R3 count before third tick", 4'h8, 32'd8);
        @(negedge clk);
        read_check("R4 count after three ticks", 4'h8, 32'd7);
        bus_write(4'h0, 32'd0);

        // R6 expiry without reset-enable
        rst_seen = 1'b0;
        bus_write(4'h4, 32'd7);
        bus_write(4'h8, 32'd1);
        bus_write(4'h0, mk_ctrl(0, 0, 1'b1, 1'b0));
        repeat (40) @(negedge clk);
        read_check("R6 silent reload", 4'h8, 32'd7);
        repeat (160) @(negedge clk);
        push_exp("R6 no reset without reset-enable", 32'd0);
        observe(32'(rst_seen));
        bus_write(4'h0, 32'd0);

        // R5 servicing prevents reset
        rst_seen = 1'b0;
        bus_write(4'h8, 32'd3);
        bus_write(4'h0, mk_ctrl(0, 0, 1'b1, 1'b1));
        for (int k = 0; k < 5; k++) begin
            repeat (40) @(negedge clk);
            bus_write(4'h8, 32'd3);
        end
        push_exp("R5 serviced no reset", 32'd0);
        observe(32'(rst_seen));
        bus_write(4'h0, 32'd0);

        // R9 force sequence, R3 variants, R4 reload, R7 width
        expire_run("R9 force pre0 sel0", 0, 0, 1, 32'h0100);
        expire_run("R3 pre2 sel1", 2, 1, 2, 32'h0200);
        expire_run("R3 pre0 sel3", 0, 3, 0, 32'h0300);
        expire_run("R9 force pre1 sel2", 1, 2, 1, 32'h0400);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule